// File: doc/BRIEF.md
# Timed Register Write-Protection Unlock Gate

This block guards a bank of timekeeping control registers against stray software accesses. The bank sits behind a simple register bus that carries a register index, a write strobe and write data. Software opens the bank by writing a 16-bit key to the enable register. A correct key raises an access-enable flag. The flag then drops by itself after a fixed number of slow timekeeping clock periods, with no further software action.

While the flag is high, every register in the bank may be read and written, except the leap-year indicator, which is never writable. While the flag is low, each register follows its own class:
- it stays fully accessible,
- it becomes read-only, or
- it becomes unavailable, so it reads as zero and ignores writes.

The block contains the key comparator, the timeout counter and the per-register permission decode. It drives a one-hot write-enable strobe and a read-data mask, and the register bank applies both. The slow clock arrives as a one-cycle strobe that is already synchronous to the bus clock.

Top module: `reg_unlock_gate`

## Requirements
- R1: A bus write to index 1 (the enable register) whose data bits [15:0] equal 0xA965 sets the flag `unlocked_o` on the next clock edge, whatever the value of data bits [31:16].
- R2: `en_rdata_o` carries the flag at bit 16, and every other bit of it is zero.
- R3: Once set, the flag stays high for exactly 1024 `slow_tick_i` strobes and then clears on the edge of the 1024th strobe, without any bus write.
- R4: A write to index 1 with any low half other than 0xA965, or a write of 0xA965 to any other index, changes neither the flag nor its remaining countdown.
- R5: Writing the key while the flag is high restarts the countdown at a full 1024 strobes.
- R6: Indices 0, 1, 5, 12 and 13 are always writable and readable: a write raises their strobe and the read mask is all ones, whether the flag is high or low.
- R7: While the flag is low, indices 3, 4, 6, 9 and 10 are read-only: the read mask is all ones and a write raises no strobe.
- R8: While the flag is low, index 2, indices 7 and 8, and indices 14 through 39 are unavailable: the read mask is zero and a write raises no strobe.
- R9: Index 11 (leap year) is readable at all times and never writable, whatever the state of the flag.
- R10: While the flag is high, every index from 0 to 39 except 11 is writable, and its read mask is all ones.
- R11: `wr_en_o` has at most one bit set, and only when `bus_wr_i` is high, at the bit equal to `bus_addr_i`. An index of 40 or above raises no strobe and gives a read mask of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle strobe per slow timekeeping clock period |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 6 | Register index |
| bus_wdata_i | input | 32 | Write data |
| wr_en_o | output | 40 | Per-register write-enable strobe |
| rd_mask_o | output | 32 | Read-data mask for the addressed register |
| en_rdata_o | output | 32 | Read value of the enable register |
| unlocked_o | output | 1 | Access-enable flag |

## Verification
The hardest situation to reach is the exact end of the unlock window, both after a restart and after a wrong key arrives partway through the countdown. Each case needs more than a thousand slow strobes at a known offset from the last key write. The bench holds `slow_tick_i` high for a counted number of clock cycles, so that it lands on 1023 strobes after the relevant key write. It checks that the flag is still high there, then applies one more strobe and checks that the flag has fallen.

// File: rtl/reg_unlock_gate_pkg.sv
package reg_unlock_gate_pkg;
  typedef enum logic [1:0] {
    ACC_RW       = 2'd0,
    ACC_RO       = 2'd1,
    ACC_NA       = 2'd2,
    ACC_FIXED_RO = 2'd3
  } acc_cls_e;

  localparam logic [15:0] UNLOCK_KEY = 16'hA965;
  localparam int EN_IDX     = 1;
  localparam int LEAP_IDX   = 11;
  localparam int SPARE_BASE = 16;
  localparam int TAIL_REGS  = 4;
  localparam int FLAG_BIT   = 16;

  // Class of each register when the gate is locked
  function automatic acc_cls_e reg_class(input int idx);
    acc_cls_e c;
    case (idx)
      0, 1, 5, 12, 13: c = ACC_RW;
      3, 4, 6, 9, 10:  c = ACC_RO;
      LEAP_IDX:        c = ACC_FIXED_RO;
      default:         c = ACC_NA;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/key_detect.sv
module key_detect
  import reg_unlock_gate_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          key_hit_o
);
  always_comb begin
    key_hit_o = wr_i && (addr_i == AW'(EN_IDX)) && (wdata_i[15:0] == UNLOCK_KEY);
  end
endmodule

// File: rtl/unlock_timer.sv
module unlock_timer #(
  parameter int WINDOW = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_hit_i,
  input  logic tick_i,
  output logic flag_o
);
  localparam int CW = $clog2(WINDOW + 1);

  logic          flag_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (key_hit_i) begin
      // key wins over a coincident tick: full reload
      flag_q <= 1'b1;
      cnt_q  <= CW'(WINDOW);
    end else if (flag_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/perm_decode.sv
module perm_decode
  import reg_unlock_gate_pkg::*;
#(
  parameter int NREG = 40,
  parameter int AW   = 6,
  parameter int DW   = 32
) (
  input  logic            unlocked_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] wr_en_o,
  output logic [DW-1:0]   rd_mask_o
);
  logic [NREG-1:0] rd_ok;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam acc_cls_e CLS = reg_class(i);
    logic hit, can_wr, can_rd;
    always_comb begin
      hit    = (addr_i == AW'(i));
      can_wr = (CLS == ACC_RW) || ((CLS != ACC_FIXED_RO) && unlocked_i);
      can_rd = (CLS != ACC_NA) || unlocked_i;
    end
    assign wr_en_o[i] = wr_i && hit && can_wr;
    assign rd_ok[i]   = hit && can_rd;
  end

  assign rd_mask_o = (|rd_ok) ? {DW{1'b1}} : '0;
endmodule

// File: rtl/reg_unlock_gate.sv
module reg_unlock_gate
  import reg_unlock_gate_pkg::*;
#(
  parameter int NSPARE = 20,
  parameter int DW     = 32,
  parameter int WINDOW = 1024,
  localparam int NREG  = SPARE_BASE + NSPARE + TAIL_REGS,
  localparam int AW    = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slow_tick_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [NREG-1:0] wr_en_o,
  output logic [DW-1:0]   rd_mask_o,
  output logic [DW-1:0]   en_rdata_o,
  output logic            unlocked_o
);
  logic key_hit;
  logic flag;

  key_detect #(.AW(AW), .DW(DW)) u_key (
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .key_hit_o (key_hit)
  );

  unlock_timer #(.WINDOW(WINDOW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_hit_i (key_hit),
    .tick_i    (slow_tick_i),
    .flag_o    (flag)
  );

  perm_decode #(.NREG(NREG), .AW(AW), .DW(DW)) u_perm (
    .unlocked_i (flag),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wr_en_o    (wr_en_o),
    .rd_mask_o  (rd_mask_o)
  );

  always_comb begin
    en_rdata_o           = '0;
    en_rdata_o[FLAG_BIT] = flag;
  end

  assign unlocked_o = flag;
endmodule

// File: rtl/reg_unlock_gate_chk.sv
module reg_unlock_gate_chk #(
  parameter int NREG   = 40,
  parameter int AW     = 6,
  parameter int DW     = 32,
  parameter int WINDOW = 1024
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            slow_tick_i,
  input logic            bus_wr_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [NREG-1:0] wr_en_o,
  input logic [DW-1:0]   en_rdata_o,
  input logic            unlocked_o
);
  localparam int CW = $clog2(WINDOW + 1);

  logic          key_wr;
  logic [CW-1:0] ticks_seen;

  assign key_wr = bus_wr_i && (bus_addr_i == AW'(1)) && (bus_wdata_i[15:0] == 16'hA965);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ticks_seen <= '0;
    else if (key_wr)                    ticks_seen <= '0;
    else if (unlocked_o && slow_tick_i) ticks_seen <= ticks_seen + 1'b1;
  end

  // R1: key write opens the gate
  a_r1_key_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> unlocked_o);

  // R2: flag mirrored at bit 16
  a_r2_flag_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rdata_o[16] == unlocked_o);

  // R3: window never exceeds its length
  a_r3_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |-> ticks_seen < CW'(WINDOW));

  // R3: the flag drops only at the end of a full window
  a_r3_full_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_o) |-> (ticks_seen == CW'(WINDOW)) && $past(slow_tick_i));

  // R4: other writes do not open the gate
  a_r4_no_false_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && !key_wr) |=> !unlocked_o);

  // R9: the leap-year register is never written
  a_r9_leap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o[11]);

  // R11: strobe is one-hot and qualified by the bus write
  a_r11_onehot_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o) && (bus_wr_i || (wr_en_o == '0)));
endmodule

bind reg_unlock_gate reg_unlock_gate_chk #(
  .NREG(NREG), .AW(AW), .DW(DW), .WINDOW(WINDOW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slow_tick_i (slow_tick_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .wr_en_o     (wr_en_o),
  .en_rdata_o  (en_rdata_o),
  .unlocked_o  (unlocked_o)
);

// File: tb/reg_unlock_gate_test.sv
`timescale 1ns/1ps
module reg_unlock_gate_test;
  localparam int NREG = 40;
  localparam int AW   = 6;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            slow_tick_i = 1'b0;
  logic            bus_wr_i = 1'b0;
  logic [AW-1:0]   bus_addr_i = '0;
  logic [DW-1:0]   bus_wdata_i = '0;
  logic [NREG-1:0] wr_en_o;
  logic [DW-1:0]   rd_mask_o;
  logic [DW-1:0]   en_rdata_o;
  logic            unlocked_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  reg_unlock_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .wr_en_o(wr_en_o), .rd_mask_o(rd_mask_o), .en_rdata_o(en_rdata_o),
    .unlocked_o(unlocked_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 always RW, 1 RO when locked, 2 NA when locked, 3 leap, 4 no register
  function automatic int exp_cls(input int a);
    if (a >= 40) return 4;
    if (a == 11) return 3;
    if (a == 0 || a == 1 || a == 5 || a == 12 || a == 13) return 0;
    if (a == 3 || a == 4 || a == 6 || a == 9 || a == 10) return 1;
    return 2;
  endfunction

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    slow_tick_i = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick_i = 1'b0;
  endtask

  // Probe one index with a non-key write and check strobe and mask
  task automatic probe(input int a, input bit unl);
    int c;
    logic [NREG-1:0] ew;
    logic [DW-1:0] em;
    string tag;
    c = exp_cls(a);
    ew = '0; em = '0;
    case (c)
      0: begin ew[a] = 1'b1; em = '1; tag = "R6"; end
      1: begin if (unl) ew[a] = 1'b1; em = '1; tag = unl ? "R10" : "R7"; end
      2: begin if (unl) ew[a] = 1'b1; if (unl) em = '1; tag = unl ? "R10" : "R8"; end
      3: begin em = '1; tag = "R9"; end
      default: tag = "R11";
    endcase
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = 32'h0000_1234;
    #1;
    check(wr_en_o == ew, $sformatf("%s wr_en idx %0d", tag, a), 64'(wr_en_o), 64'(ew));
    check(rd_mask_o == em, $sformatf("%s rd_mask idx %0d", tag, a), 64'(rd_mask_o), 64'(em));
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    check(unlocked_o == 1'b0, "R3 reset flag", 64'(unlocked_o), 64'd0);
    check(en_rdata_o == '0, "R2 reset en_rdata", 64'(en_rdata_o), 64'd0);
    check(wr_en_o == '0, "R11 idle strobe", 64'(wr_en_o), 64'd0);
  endtask

  task automatic t_locked_map();
    for (int a = 0; a < 64; a++) probe(a, 1'b0);
    check(unlocked_o == 1'b0, "R4 probes keep lock", 64'(unlocked_o), 64'd0);
  endtask

  task automatic t_bad_keys();
    bus_write(1, 32'h0000_A964);
    check(unlocked_o == 1'b0, "R4 wrong key", 64'(unlocked_o), 64'd0);
    bus_write(5, 32'h0000_A965);
    check(unlocked_o == 1'b0, "R4 key at wrong index", 64'(unlocked_o), 64'd0);
  endtask

  task automatic t_unlock_map();
    bus_write(1, 32'hFFFF_A965);
    check(unlocked_o == 1'b1, "R1 key with upper bits", 64'(unlocked_o), 64'd1);
    check(en_rdata_o == 32'h0001_0000, "R2 flag at bit 16", 64'(en_rdata_o), 64'h10000);
    for (int a = 0; a < 64; a++) probe(a, 1'b1);
  endtask

  task automatic t_timeout();
    bus_write(1, 32'h0000_A965);
    check(unlocked_o == 1'b1, "R1 unlock", 64'(unlocked_o), 64'd1);
    ticks(1023);
    check(unlocked_o == 1'b1, "R3 held at 1023", 64'(unlocked_o), 64'd1);
    ticks(1);
    check(unlocked_o == 1'b0, "R3 cleared at 1024", 64'(unlocked_o), 64'd0);
    check(en_rdata_o == '0, "R2 flag cleared", 64'(en_rdata_o), 64'd0);
    probe(3, 1'b0);
  endtask

  task automatic t_restart();
    bus_write(1, 32'h0000_A965);
    ticks(500);
    bus_write(1, 32'h1234_A965);
    ticks(1023);
    check(unlocked_o == 1'b1, "R5 restarted window held", 64'(unlocked_o), 64'd1);
    ticks(1);
    check(unlocked_o == 1'b0, "R5 restarted window ends", 64'(unlocked_o), 64'd0);
  endtask

  task automatic t_wrong_while_open();
    bus_write(1, 32'h0000_A965);
    ticks(600);
    bus_write(1, 32'h0000_5A96);
    bus_write(2, 32'h0000_A965);
    check(unlocked_o == 1'b1, "R4 wrong key while open", 64'(unlocked_o), 64'd1);
    ticks(423);
    check(unlocked_o == 1'b1, "R4 countdown kept at 1023", 64'(unlocked_o), 64'd1);
    ticks(1);
    check(unlocked_o == 1'b0, "R4 countdown not extended", 64'(unlocked_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_map();
    t_bad_keys();
    t_unlock_map();
    ticks(1024);
    t_timeout();
    t_restart();
    t_wrong_while_open();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule